// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block runs maintenance commands against the tag, dirty and data state of a set-associative write-back cache. Each line holds a valid bit, a tag, two dirty flags (one per half of the line) and the line data. The commands are: clean or invalidate a line found by address, clean or invalidate a line picked by a set/way index word, invalidate the whole cache, flush the line picked by a physical address, and a query that finds the first dirty line. Dirty halves go out one word at a time through a memory write port with a valid/ready handshake. Each command ends with a one-cycle done pulse that carries a found flag and a set/way result.

The line storage sits inside the block. The processor side writes lines into it through a fill port. That port is held off whenever the sequencer owns the arrays. Commands come in over a valid/ready port, one at a time.

The controller has seven states:
- IDLE: accept a command, or a fill.
- LOOKUP: compare the tags of the addressed set.
- CHECK: read the target line and decide whether a write-back is needed.
- WB: stream the dirty words.
- POST: update the tag state.
- SCAN: walk the lines for the dirty query.
- DONE: pulse completion.

The transitions are:
- IDLE→LOOKUP for address commands.
- IDLE→CHECK for set/way, flush and invalidate-all.
- IDLE→SCAN for the query.
- IDLE→DONE for the reserved opcode.
- LOOKUP→CHECK on a hit, and LOOKUP→DONE on a miss.
- CHECK→WB when the line is valid with a dirty half, otherwise CHECK→POST.
- WB→POST after the last word is accepted.
- POST→CHECK to advance invalidate-all, otherwise POST→DONE.
- SCAN→SCAN to advance, and SCAN→DONE when a dirty line is found or the last line is reached.
- DONE→IDLE.

Top module: `cmo_engine`

## Requirements
- R1: Opcodes on `cmd_op`: 0 clean-by-address, 1 invalidate-by-address, 2 clean-by-index, 3 invalidate-by-index, 4 invalidate-all, 5 flush-by-physical-address, 6 dirty query, 7 reserved. `cmd_ready` is high only when idle. Every accepted command yields exactly one single-cycle `done` pulse. Opcode 7 completes with `done_found`=0 and changes nothing.
- R2: A fill is written only in a cycle where `fill_valid` and `fill_ready` are both high. `fill_ready` is low while a command is in progress and in a cycle where `cmd_valid` is high. A fill offered while the sequencer is busy leaves the storage unchanged.
- R3: Address fields: byte offset is bits [3:0], set is bits [6:4], tag is bits [31:7]. A line hits when it is valid and its tag matches; the lowest hitting way wins. Clean-by-address on a hit writes back the dirty halves, clears both dirty flags and keeps the line valid, with `done_found`=1 and the hit set/way. On a miss it writes nothing and `done_found`=0.
- R4: Invalidate-by-address on a hit first writes back the dirty halves, then clears valid, tag and dirty flags. A later lookup of that address misses.
- R5: Dirty flag bit 0 covers words 0 and 1, and bit 1 covers words 2 and 3. Words go out in ascending order to address {tag, set, word index, 2'b00}. A line that is not valid is never written back, whatever its dirty flags.
- R6: Index commands take the way from bits [31:30] of the argument and the set from bits [6:4]. `done_found` reports whether that line was valid. The clean form (2) clears the dirty flags of a valid line only. The invalidate form (3) writes back and then clears the line.
- R7: Invalidate-all visits sets in ascending order, and ways in ascending order within each set. It writes back each valid dirty line in that order and clears every line. `done_found`=0.
- R8: Flush-by-physical-address takes the way from argument bits [5:4] and the set from bits [8:6]. It writes back that line if it is valid and dirty, then clears it. `done_found` reports prior validity.
- R9: The dirty query scans set-major and way-ascending, and reports the first line with either dirty flag set, valid or not, in `done_set`/`done_way` with `done_found`=1. It reports `done_found`=0 when no line is dirty. It writes nothing and changes nothing.
- R10: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_addr` and `wb_data` hold their values.
- R11: After reset every line is invalid and clean, `cmd_ready` and `fill_ready` are high, and `done` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | 32 | Address, index word or physical address |
| done | output | 1 | One-cycle completion pulse |
| done_found | output | 1 | Hit / valid / dirty-found flag |
| done_set | output | 3 | Set of the result line |
| done_way | output | 2 | Way of the result line |
| fill_valid | input | 1 | Line write offered |
| fill_ready | output | 1 | Line write accepted when high with fill_valid |
| fill_set | input | 3 | Set to write |
| fill_way | input | 2 | Way to write |
| fill_line_valid | input | 1 | Valid bit to store |
| fill_tag | input | 25 | Tag to store |
| fill_dirty | input | 2 | Half-dirty flags to store |
| fill_data | input | 128 | Line data, word k at bits [32k+31:32k] |
| wb_valid | output | 1 | Write-back word offered |
| wb_ready | input | 1 | Memory accepts the word |
| wb_addr | output | 32 | Write-back byte address |
| wb_data | output | 32 | Write-back word |

## Verification
Wrong internal tag or dirty state can hide for many cycles, so the bench exposes it through later commands. A dirty flag that was not cleared shows up as extra write-back words, or as a wrong dirty-query location, on the next command that touches that line. A valid bit that was left set shows up as a hit where a miss is expected. A walk counter that goes wrong shows up at once as out-of-order write-back addresses during invalidate-all, or as a wrong set/way in the done result of the same command.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    typedef enum logic [2:0] {
        OP_CLEAN_VA   = 3'd0,
        OP_INV_VA     = 3'd1,
        OP_CLEAN_SW   = 3'd2,
        OP_INV_SW     = 3'd3,
        OP_INV_ALL    = 3'd4,
        OP_FLUSH_PA   = 3'd5,
        OP_FIND_DIRTY = 3'd6,
        OP_RSVD       = 3'd7
    } cmo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_CHECK,
        ST_WB,
        ST_POST,
        ST_SCAN,
        ST_DONE
    } cmo_state_e;

    function automatic logic op_invalidates(input cmo_op_e op);
        return (op == OP_INV_VA) || (op == OP_INV_SW) ||
               (op == OP_INV_ALL) || (op == OP_FLUSH_PA);
    endfunction

endpackage

// File: rtl/cmo_line_store.sv
module cmo_line_store #(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 25
) (
    input  logic                          clk,
    input  logic                          rst_n,
    // processor-side line write
    input  logic                          fill_we,
    input  logic [$clog2(SETS)-1:0]       fill_set,
    input  logic [$clog2(WAYS)-1:0]       fill_way,
    input  logic                          fill_vbit,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [1:0]                    fill_dirty,
    input  logic [WORDS*DATA_W-1:0]       fill_data,
    // maintenance update
    input  logic                          m_we,
    input  logic                          m_inval,
    input  logic [$clog2(SETS)-1:0]       m_set,
    input  logic [$clog2(WAYS)-1:0]       m_way,
    // set-wide read for tag compare
    input  logic [$clog2(SETS)-1:0]       rd_set,
    output logic [WAYS-1:0]               set_valid,
    output logic [WAYS-1:0][TAG_W-1:0]    set_tag,
    // single line read
    input  logic [$clog2(WAYS)-1:0]       rd_way,
    output logic                          line_valid,
    output logic [1:0]                    line_dirty,
    output logic [TAG_W-1:0]              line_tag,
    output logic [WORDS*DATA_W-1:0]       line_data
);
    localparam int SB = $clog2(SETS);
    localparam int WB = $clog2(WAYS);

    logic                    valid_r [SETS][WAYS];
    logic [1:0]              dirty_r [SETS][WAYS];
    logic [TAG_W-1:0]        tag_r   [SETS][WAYS];
    logic [WORDS*DATA_W-1:0] data_r  [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_r[s][w] <= 1'b0;
                    dirty_r[s][w] <= 2'b00;
                    tag_r[s][w]   <= '0;
                end
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (fill_we && fill_set == SB'(s) && fill_way == WB'(w)) begin
                        valid_r[s][w] <= fill_vbit;
                        dirty_r[s][w] <= fill_dirty;
                        tag_r[s][w]   <= fill_tag;
                    end else if (m_we && m_set == SB'(s) && m_way == WB'(w)) begin
                        dirty_r[s][w] <= 2'b00;
                        if (m_inval) begin
                            valid_r[s][w] <= 1'b0;
                            tag_r[s][w]   <= '0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (fill_we && fill_set == SB'(s) && fill_way == WB'(w)) begin
                    data_r[s][w] <= fill_data;
                end
            end
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_valid[w] = valid_r[rd_set][w];
            set_tag[w]   = tag_r[rd_set][w];
        end
    end

    assign line_valid = valid_r[rd_set][rd_way];
    assign line_dirty = dirty_r[rd_set][rd_way];
    assign line_tag   = tag_r[rd_set][rd_way];
    assign line_data  = data_r[rd_set][rd_way];

    // the two write sources never collide: fills are held off while busy
    assert_write_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_we && m_we));

endmodule

// File: rtl/cmo_hit_find.sv
module cmo_hit_find #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 25
) (
    input  logic [WAYS-1:0]            set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] set_tag,
    input  logic [TAG_W-1:0]           want_tag,
    output logic                       any_hit,
    output logic [$clog2(WAYS)-1:0]    hit_way
);
    localparam int WB = $clog2(WAYS);

    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_valid[w] && (set_tag[w] == want_tag);
    end

    // lowest matching way has priority
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WB'(w);
        end
    end

    assign any_hit = |hit_vec;

endmodule

// File: rtl/cmo_wb_seq.sv
module cmo_wb_seq #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [1:0]                        start_dirty,
    input  logic [ADDR_W-$clog2(WORDS)-3:0]   start_line,
    input  logic [WORDS*DATA_W-1:0]           start_data,
    output logic                              wb_valid,
    input  logic                              wb_ready,
    output logic [ADDR_W-1:0]                 wb_addr,
    output logic [DATA_W-1:0]                 wb_data,
    output logic                              fin
);
    localparam int WDB  = $clog2(WORDS);
    localparam int LA_W = ADDR_W - WDB - 2;
    localparam logic [WDB-1:0] HALF = WDB'(WORDS / 2);
    localparam logic [WDB-1:0] TOP  = WDB'(WORDS - 1);

    logic                    active_q;
    logic [WDB-1:0]          ptr_q;
    logic [WDB-1:0]          last_q;
    logic [LA_W-1:0]         line_q;
    logic [WORDS*DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ptr_q    <= '0;
            last_q   <= '0;
            line_q   <= '0;
            data_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            ptr_q    <= start_dirty[0] ? '0 : HALF;
            last_q   <= start_dirty[1] ? TOP : HALF - WDB'(1);
            line_q   <= start_line;
            data_q   <= start_data;
        end else if (active_q && wb_ready) begin
            if (ptr_q == last_q) active_q <= 1'b0;
            else                 ptr_q    <= ptr_q + WDB'(1);
        end
    end

    assign wb_valid = active_q;
    assign wb_addr  = {line_q, ptr_q, 2'b00};
    assign wb_data  = data_q[ptr_q*DATA_W +: DATA_W];
    assign fin      = active_q && wb_ready && (ptr_q == last_q);

    assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

    assert_no_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active_q);

endmodule

// File: rtl/cmo_engine.sv
module cmo_engine
    import cmo_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int SB    = $clog2(SETS),
    localparam int WB    = $clog2(WAYS),
    localparam int OFF   = $clog2(WORDS) + 2,
    localparam int TAG_W = ADDR_W - OFF - SB
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [2:0]              cmd_op,
    input  logic [ADDR_W-1:0]       cmd_arg,
    output logic                    done,
    output logic                    done_found,
    output logic [SB-1:0]           done_set,
    output logic [WB-1:0]           done_way,
    input  logic                    fill_valid,
    output logic                    fill_ready,
    input  logic [SB-1:0]           fill_set,
    input  logic [WB-1:0]           fill_way,
    input  logic                    fill_line_valid,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [1:0]              fill_dirty,
    input  logic [WORDS*DATA_W-1:0] fill_data,
    output logic                    wb_valid,
    input  logic                    wb_ready,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [DATA_W-1:0]       wb_data
);
    localparam logic [SB-1:0] LAST_SET = SB'(SETS - 1);
    localparam logic [WB-1:0] LAST_WAY = WB'(WAYS - 1);

    cmo_state_e state_q, state_d;
    cmo_op_e    op_q, op_in;
    logic [ADDR_W-1:0] arg_q;
    logic [SB-1:0]     set_q;
    logic [WB-1:0]     way_q;
    logic              found_q;

    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0][TAG_W-1:0] set_tag;
    logic                       line_valid;
    logic [1:0]                 line_dirty;
    logic [TAG_W-1:0]           line_tag;
    logic [WORDS*DATA_W-1:0]    line_data;
    logic                       any_hit;
    logic [WB-1:0]              hit_way;
    logic                       wb_start, wb_fin, fill_we, m_we, at_last, line_needs_wb;

    assign op_in         = cmo_op_e'(cmd_op);
    assign at_last       = (set_q == LAST_SET) && (way_q == LAST_WAY);
    assign line_needs_wb = line_valid && (line_dirty != 2'b00);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_in)
                        OP_CLEAN_VA, OP_INV_VA:                        state_d = ST_LOOKUP;
                        OP_CLEAN_SW, OP_INV_SW, OP_INV_ALL, OP_FLUSH_PA: state_d = ST_CHECK;
                        OP_FIND_DIRTY:                                 state_d = ST_SCAN;
                        OP_RSVD:                                       state_d = ST_DONE;
                    endcase
                end
            end
            ST_LOOKUP: state_d = any_hit ? ST_CHECK : ST_DONE;
            ST_CHECK:  state_d = line_needs_wb ? ST_WB : ST_POST;
            ST_WB:     if (wb_fin) state_d = ST_POST;
            ST_POST:   state_d = (op_q == OP_INV_ALL && !at_last) ? ST_CHECK : ST_DONE;
            ST_SCAN:   if (line_dirty != 2'b00 || at_last) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- command datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_RSVD;
            arg_q   <= '0;
            set_q   <= '0;
            way_q   <= '0;
            found_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q    <= op_in;
                        arg_q   <= cmd_arg;
                        found_q <= 1'b0;
                        unique case (op_in)
                            OP_CLEAN_SW, OP_INV_SW: begin
                                set_q <= cmd_arg[OFF +: SB];
                                way_q <= cmd_arg[ADDR_W-1 -: WB];
                            end
                            OP_FLUSH_PA: begin
                                way_q <= cmd_arg[OFF +: WB];
                                set_q <= cmd_arg[OFF+WB +: SB];
                            end
                            OP_CLEAN_VA, OP_INV_VA: begin
                                set_q <= cmd_arg[OFF +: SB];
                                way_q <= '0;
                            end
                            default: begin
                                set_q <= '0;
                                way_q <= '0;
                            end
                        endcase
                    end
                end
                ST_LOOKUP: begin
                    if (any_hit) begin
                        way_q   <= hit_way;
                        found_q <= 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (op_q == OP_CLEAN_SW || op_q == OP_INV_SW || op_q == OP_FLUSH_PA)
                        found_q <= line_valid;
                end
                ST_POST: begin
                    if (op_q == OP_INV_ALL && !at_last) begin
                        if (way_q == LAST_WAY) begin
                            way_q <= '0;
                            set_q <= set_q + SB'(1);
                        end else begin
                            way_q <= way_q + WB'(1);
                        end
                    end
                end
                ST_SCAN: begin
                    if (line_dirty != 2'b00) begin
                        found_q <= 1'b1;
                    end else if (!at_last) begin
                        if (way_q == LAST_WAY) begin
                            way_q <= '0;
                            set_q <= set_q + SB'(1);
                        end else begin
                            way_q <= way_q + WB'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs and array controls ----------------
    assign cmd_ready  = (state_q == ST_IDLE);
    assign fill_ready = (state_q == ST_IDLE) && !cmd_valid;
    assign fill_we    = fill_valid && fill_ready;
    assign wb_start   = (state_q == ST_CHECK) && line_needs_wb;
    assign m_we       = (state_q == ST_POST) && (line_valid || op_invalidates(op_q));
    assign done       = (state_q == ST_DONE);
    assign done_found = found_q;
    assign done_set   = set_q;
    assign done_way   = way_q;

    cmo_line_store #(
        .SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_we(fill_we), .fill_set(fill_set), .fill_way(fill_way),
        .fill_vbit(fill_line_valid), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
        .fill_data(fill_data),
        .m_we(m_we), .m_inval(op_invalidates(op_q)), .m_set(set_q), .m_way(way_q),
        .rd_set(set_q), .set_valid(set_valid), .set_tag(set_tag),
        .rd_way(way_q), .line_valid(line_valid), .line_dirty(line_dirty),
        .line_tag(line_tag), .line_data(line_data)
    );

    cmo_hit_find #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
        .set_valid(set_valid), .set_tag(set_tag),
        .want_tag(arg_q[ADDR_W-1 -: TAG_W]),
        .any_hit(any_hit), .hit_way(hit_way)
    );

    cmo_wb_seq #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wb (
        .clk(clk), .rst_n(rst_n),
        .start(wb_start), .start_dirty(line_dirty),
        .start_line({line_tag, set_q}), .start_data(line_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_data(wb_data), .fin(wb_fin)
    );

    // ---------------- assertions ----------------
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_single_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_fill_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ready |-> !wb_valid);

    assert_query_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (!wb_valid && !m_we));

    assert_wb_only_when_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (state_q == ST_WB));

endmodule

// File: tb/cmo_engine_bench.sv
module cmo_engine_bench;
    localparam int NS = 8, NW = 4, NWD = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, cmd_ready;
    logic [2:0] cmd_op = 0;
    logic [31:0] cmd_arg = 0;
    logic done, done_found;
    logic [2:0] done_set;
    logic [1:0] done_way;
    logic fill_valid = 0, fill_ready, fill_line_valid = 0;
    logic [2:0] fill_set = 0;
    logic [1:0] fill_way = 0, fill_dirty = 0;
    logic [24:0] fill_tag = 0;
    logic [127:0] fill_data = 0;
    logic wb_valid, wb_ready = 0;
    logic [31:0] wb_addr, wb_data;

    always #10 clk = ~clk;

    cmo_engine u_cmo_engine (.*);

    // reference state
    logic        mv  [NS][NW];
    logic [24:0] mt  [NS][NW];
    logic [1:0]  md  [NS][NW];
    logic [31:0] mdat[NS][NW][NWD];
    logic [63:0] exp_q[$];
    logic [63:0] act_q[$];
    int vecs = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2, 3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R1";
        endcase
    endfunction

    // R5: dirty halves, ascending words, valid lines only
    task automatic m_wb(input int s, input int w);
        if (mv[s][w] && md[s][w] != 2'b00) begin
            for (int k = 0; k < NWD; k++) begin
                if ((k < NWD/2) ? md[s][w][0] : md[s][w][1])
                    exp_q.push_back({mt[s][w], 3'(s), 2'(k), 2'b00, mdat[s][w][k]});
            end
            md[s][w] = 2'b00;
        end
    endtask

    task automatic m_inv(input int s, input int w);
        mv[s][w] = 1'b0; md[s][w] = 2'b00; mt[s][w] = '0;
    endtask

    task automatic model_cmd(input logic [2:0] op, input logic [31:0] a,
                             output logic f, output int fs, output int fw);
        f = 0; fs = 0; fw = 0;
        case (op)
            3'd0, 3'd1: begin
                fs = int'(a[6:4]);
                for (int w = 0; w < NW; w++)
                    if (!f && mv[fs][w] && mt[fs][w] == a[31:7]) begin f = 1; fw = w; end
                if (f) begin m_wb(fs, fw); if (op == 3'd1) m_inv(fs, fw); end
            end
            3'd2, 3'd3: begin
                fs = int'(a[6:4]); fw = int'(a[31:30]); f = mv[fs][fw];
                m_wb(fs, fw); if (op == 3'd3) m_inv(fs, fw);
            end
            3'd4: begin
                for (int s = 0; s < NS; s++)
                    for (int w = 0; w < NW; w++) begin m_wb(s, w); m_inv(s, w); end
            end
            3'd5: begin
                fw = int'(a[5:4]); fs = int'(a[8:6]); f = mv[fs][fw];
                m_wb(fs, fw); m_inv(fs, fw);
            end
            3'd6: begin
                for (int s = 0; s < NS; s++)
                    for (int w = 0; w < NW; w++)
                        if (!f && md[s][w] != 2'b00) begin f = 1; fs = s; fw = w; end
            end
            default: ;
        endcase
    endtask

    // memory side: random ready, record accepted words
    always @(negedge clk) begin
        if (rst_n) begin
            wb_ready = ($urandom % 4) != 0;
            if (wb_valid && wb_ready) act_q.push_back({wb_addr, wb_data});
        end
    end

    task automatic fill(input int s, input int w, input logic v, input logic [24:0] t, input logic [1:0] d);
        @(negedge clk);
        fill_valid = 1; fill_set = 3'(s); fill_way = 2'(w);
        fill_line_valid = v; fill_tag = t; fill_dirty = d;
        for (int k = 0; k < NWD; k++) begin
            mdat[s][w][k] = $urandom;
            fill_data[k*32 +: 32] = mdat[s][w][k];
        end
        mv[s][w] = v; mt[s][w] = t; md[s][w] = d;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [31:0] a, input bit poke);
        logic ef; int es, ew, t;
        string r;
        r = req_of(op);
        model_cmd(op, a, ef, es, ew);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_arg = a;
        if (poke) begin
            fill_valid = 1; fill_set = 3'd0; fill_way = 2'd3; fill_line_valid = 1;
            fill_tag = 25'h1ABCDE; fill_dirty = 2'b11; fill_data = {4{32'hDEADBEEF}};
        end
        @(negedge clk);
        cmd_valid = 0;
        chk(!fill_ready && !cmd_ready, "R2 busy blocks fill/cmd", {62'd0, fill_ready, cmd_ready}, 64'd0);
        t = 0;
        while (!done && t < 2000) begin @(negedge clk); t++; end
        chk(done, {r, " done pulse (R1)"}, 64'(done), 64'd1);
        chk(done_found == ef, {r, " found"}, 64'(done_found), 64'(ef));
        if (ef) chk(done_set == 3'(es) && done_way == 2'(ew), {r, " set/way"},
                    {done_set, done_way}, {3'(es), 2'(ew)});
        fill_valid = 0;
        @(negedge clk);
        chk(!done, "R1 single-cycle done", 64'(done), 64'd0);
        chk(act_q.size() == exp_q.size(), {r, " R5 write-back count"}, 64'(act_q.size()), 64'(exp_q.size()));
        if (act_q.size() == exp_q.size())
            foreach (exp_q[i]) chk(act_q[i] == exp_q[i], {r, " R5 write-back word"}, act_q[i], exp_q[i]);
        act_q.delete(); exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; vecs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 0; mt[s][w] = 0; md[s][w] = 0;
                for (int k = 0; k < NWD; k++) mdat[s][w][k] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(cmd_ready && fill_ready, "R11 ready after reset", {62'd0, cmd_ready, fill_ready}, 64'd3);
        chk(!done && !wb_valid, "R11 idle outputs", {62'd0, done, wb_valid}, 64'd0);
        run_cmd(3'd6, 32'd0, 0);                              // R11/R9: nothing dirty
        // R3 lower half dirty, then clean again writes nothing
        fill(2, 1, 1, 25'h0AAAA, 2'b01);
        run_cmd(3'd0, {25'h0AAAA, 3'd2, 4'h8}, 0);
        run_cmd(3'd0, {25'h0AAAA, 3'd2, 4'h0}, 0);
        // R4 upper half, then miss
        fill(2, 3, 1, 25'h0BBBB, 2'b10);
        run_cmd(3'd1, {25'h0BBBB, 3'd2, 4'h4}, 0);
        run_cmd(3'd0, {25'h0BBBB, 3'd2, 4'h4}, 0);
        // R5/R6 invalid dirty line: no write-back, still seen by R9 query
        fill(5, 0, 0, 25'h0CCCC, 2'b11);
        run_cmd(3'd2, {2'd0, 23'h12345, 3'd5, 4'h0}, 0);
        run_cmd(3'd6, 32'd0, 0);
        // R6 invalidate by index, both halves
        fill(1, 2, 1, 25'h0DDDD, 2'b11);
        run_cmd(3'd3, {2'd2, 23'h7FFFF, 3'd1, 4'hC}, 0);
        // R8 flush by physical address: set 6 way 3
        fill(6, 3, 1, 25'h0EEEE, 2'b11);
        run_cmd(3'd5, {23'h0, 3'd6, 2'd3, 4'h0}, 0);
        // R1 reserved opcode
        fill(0, 0, 1, 25'h01111, 2'b11);
        run_cmd(3'd7, 32'hFFFF_FFFF, 0);
        // R7 invalidate-all with a fill offered while busy (R2), then poked line misses
        fill(7, 3, 1, 25'h02222, 2'b01);
        run_cmd(3'd4, 32'd0, 1);
        run_cmd(3'd0, {25'h1ABCDE, 3'd0, 4'h0}, 0);
        // random mix
        for (int n = 0; n < 500; n++) begin
            int nf; logic [2:0] op; logic [31:0] a; int s;
            nf = $urandom % 3;
            for (int j = 0; j < nf; j++)
                fill($urandom % NS, $urandom % NW, ($urandom % 8) != 0, 25'($urandom % 4), 2'($urandom));
            op = 3'($urandom);
            s = $urandom % NS;
            a = $urandom;
            if (op == 3'd0 || op == 3'd1) a = {25'($urandom % 4), 3'(s), 4'($urandom)};
            if (op == 3'd4 && ($urandom % 4) != 0) op = 3'd6;
            run_cmd(op, a, 0);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule